// File: doc/BRIEF.md
# ADC Sequence Result Placement Controller

This block runs the digital bookkeeping of an analog-to-digital converter's conversion sequence. A control-register write sends a start strobe. The block then counts conversion-done pulses from the converter and decides which of sixteen 10-bit result registers receives each result. When the programmed number of conversions is reached, it raises a sequence-complete flag. If repeat mode is on, it starts the next sequence on its own; otherwise it goes idle.

There are two placement policies. In the plain policy, every sequence fills the registers from register 0 upward. In ring mode, the write index keeps advancing across sequence boundaries and wraps from the last register back to register 0. A start strobe always brings the index back to register 0, in both policies.

Each register has its own valid flag. The current write index is brought out, so software can see where the next result will go.

Top module: `adc_seq_place`

## Requirements
- R1: After reset, all result registers and valid flags read 0, the sequence-complete flag is 0, the write index is 0 and the block is idle (`busy` = 0).
- R2: With `ringMode` = 0, the k-th conversion of a sequence (counting from 0) is stored in result register k (bits `10*k+9 : 10*k` of `resultFlat`), and every new sequence starts again at register 0.
- R3: With `ringMode` = 1, the write index is not reset when a sequence ends, so consecutive results go to consecutive registers across sequence boundaries.
- R4: With `ringMode` = 1, a result stored in register 15 is followed by a result stored in register 0.
- R5: A start strobe sets the write index to 0 and makes the block busy, in either mode and even in the middle of a sequence. The next accepted result lands in register 0.
- R6: `convIdx` always shows the register that the next accepted result will be written to.
- R7: `seqLenCode` values 1 to 15 select that many conversions per sequence, and the value 0 selects 16.
- R8: The valid flag of a register reads 1 from the cycle after its result is written. If a write and a flag-clear bit for the same register arrive in the same cycle, the flag ends up set.
- R9: A 1 on bit i of `flagClr` clears valid flag i only, and leaves all other flags and all result data unchanged.
- R10: `seqDone` reads 1 from the cycle after the last conversion of a sequence. Then, if `autoRepeat` = 1, the block stays busy and begins a new sequence; if `autoRepeat` = 0, it goes idle.
- R11: A start strobe clears every valid flag and `seqDone`. A conversion-done pulse in the same cycle as the start strobe is discarded.
- R12: A conversion-done pulse while the block is idle changes no result, flag, index or status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seqLenCode | input | 4 | Conversions per sequence; 0 selects 16 |
| ringMode | input | 1 | 1: the write index runs across sequences and wraps |
| autoRepeat | input | 1 | 1: a new sequence starts automatically after each one completes |
| startPulse | input | 1 | One-cycle start or abort strobe from a control-register write |
| convDone | input | 1 | One-cycle pulse: the converter has a result |
| convData | input | 10 | Result that accompanies `convDone` |
| flagClr | input | 16 | Per-register valid-flag clear bits |
| resultFlat | output | 160 | Result register file, register k in bits 10k+9:10k |
| resultValid | output | 16 | Per-register valid flags |
| seqDone | output | 1 | Sequence-complete flag |
| convIdx | output | 4 | Write index of the next result |
| busy | output | 1 | A sequence is in progress |

## Verification
Two pairs of events can fall in the same cycle here. A start strobe can coincide with a conversion-done pulse; the bench drives both together in the middle of a ring-mode sequence and expects the result to be dropped and the index to read 0 one cycle later. A flag-clear bit can coincide with the write to that same register; the bench aims the clear at the current `convIdx` and expects the flag to be set afterwards, while clear bits aimed at other registers still take effect. A cycle-accurate reference model in the bench judges every cycle of both cases, with every output compared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // strobes passed from sequence control to result storage
  typedef struct packed {
    logic clrAll;   // start strobe: wipe flags and sequence status
    logic wrEn;     // accepted result: store it at the write index
    logic seqEnd;   // accepted result was the last one of its sequence
  } ctlStrobes_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] seqLenCode,
  input  logic             ringMode,
  input  logic             autoRepeat,
  input  logic             startPulse,
  input  logic             convDone,
  output ctlStrobes_t      strobe,
  output logic [IDX_W-1:0] convIdx,
  output logic             active
);
  logic [IDX_W-1:0] seqCnt;
  logic [IDX_W-1:0] lastCnt;
  logic             accept;
  logic             lastConv;

  // code 0 wraps to the all-ones count, which gives NREG conversions
  assign lastCnt  = seqLenCode - IDX_W'(1);
  assign accept   = convDone && active && !startPulse;
  assign lastConv = accept && (seqCnt == lastCnt);

  always_comb begin
    strobe.clrAll = startPulse;
    strobe.wrEn   = accept;
    strobe.seqEnd = lastConv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convIdx <= '0;
      seqCnt  <= '0;
      active  <= 1'b0;
    end else if (startPulse) begin
      convIdx <= '0;
      seqCnt  <= '0;
      active  <= 1'b1;
    end else if (accept) begin
      if (lastConv) begin
        seqCnt  <= '0;
        active  <= autoRepeat;
        convIdx <= ringMode ? convIdx + IDX_W'(1) : '0;
      end else begin
        seqCnt  <= seqCnt + IDX_W'(1);
        convIdx <= convIdx + IDX_W'(1);
      end
    end
  end

  // R12
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !startPulse) |=> ($stable(convIdx) && !active));
  // R5
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (convIdx == '0 && active));
  // R3
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && ringMode) |=> (convIdx == IDX_W'($past(convIdx) + IDX_W'(1))));
  // R2
  plain_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.seqEnd && !ringMode) |=> (convIdx == '0));
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store
  import adc_seq_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int DATA_W = 10,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctlStrobes_t            strobe,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NREG-1:0]        flagClr,
  output logic [NREG*DATA_W-1:0] resultFlat,
  output logic [NREG-1:0]        flags,
  output logic                   seqDone
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = strobe.wrEn && (wrIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resultFlat[g*DATA_W +: DATA_W] <= '0;
      else if (hit) resultFlat[g*DATA_W +: DATA_W] <= wrData;
    end

    // start wipes; a set beats a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else if (strobe.clrAll) flags[g] <= 1'b0;
      else if (hit) flags[g] <= 1'b1;
      else if (flagClr[g]) flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seqDone <= 1'b0;
    else if (strobe.clrAll) seqDone <= 1'b0;
    else if (strobe.seqEnd) seqDone <= 1'b1;
  end

  // R8
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> flags[$past(wrIdx)]);
  // R11
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrAll |=> (flags == '0 && !seqDone));
  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.seqEnd |=> seqDone);
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrEn |=> $stable(resultFlat));
endmodule

// File: rtl/adc_seq_place.sv
module adc_seq_place
  import adc_seq_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int DATA_W = 10,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       seqLenCode,
  input  logic                   ringMode,
  input  logic                   autoRepeat,
  input  logic                   startPulse,
  input  logic                   convDone,
  input  logic [DATA_W-1:0]      convData,
  input  logic [NREG-1:0]        flagClr,
  output logic [NREG*DATA_W-1:0] resultFlat,
  output logic [NREG-1:0]        resultValid,
  output logic                   seqDone,
  output logic [IDX_W-1:0]       convIdx,
  output logic                   busy
);
  ctlStrobes_t strobe;

  adc_seq_ctrl #(.NREG(NREG)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .seqLenCode (seqLenCode),
    .ringMode   (ringMode),
    .autoRepeat (autoRepeat),
    .startPulse (startPulse),
    .convDone   (convDone),
    .strobe     (strobe),
    .convIdx    (convIdx),
    .active     (busy)
  );

  adc_seq_store #(.NREG(NREG), .DATA_W(DATA_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wrIdx      (convIdx),
    .wrData     (convData),
    .flagClr    (flagClr),
    .resultFlat (resultFlat),
    .flags      (resultValid),
    .seqDone    (seqDone)
  );
endmodule

// File: tb/adc_seq_place_tb.sv
module adc_seq_place_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   seqLenCode = 4'd1;
  logic         ringMode = 1'b0;
  logic         autoRepeat = 1'b0;
  logic         startPulse = 1'b0;
  logic         convDone = 1'b0;
  logic [9:0]   convData = '0;
  logic [15:0]  flagClr = '0;
  logic [159:0] resultFlat;
  logic [15:0]  resultValid;
  logic         seqDone;
  logic [3:0]   convIdx;
  logic         busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [9:0]  expRes [16];
  logic [15:0] expFlag;
  logic        expDone;
  logic [3:0]  expIdx;
  logic        expBusy;
  int          expCnt;

  always #2 clk = ~clk;

  adc_seq_place dut_i (
    .clk(clk), .rst_n(rst_n), .seqLenCode(seqLenCode), .ringMode(ringMode),
    .autoRepeat(autoRepeat), .startPulse(startPulse), .convDone(convDone),
    .convData(convData), .flagClr(flagClr), .resultFlat(resultFlat),
    .resultValid(resultValid), .seqDone(seqDone), .convIdx(convIdx), .busy(busy)
  );

  task automatic check(input string tag, input string what,
                       input logic [159:0] got, input logic [159:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [159:0] flat;
    for (int i = 0; i < 16; i++) flat[i*10 +: 10] = expRes[i];
    check(tag, "convIdx", 160'(convIdx), 160'(expIdx));
    check(tag, "resultValid", 160'(resultValid), 160'(expFlag));
    check(tag, "seqDone", 160'(seqDone), 160'(expDone));
    check(tag, "busy", 160'(busy), 160'(expBusy));
    check(tag, "resultFlat", resultFlat, flat);
  endtask

  task automatic modelStep(input logic st, input logic cv, input logic [9:0] d,
                           input logic [15:0] clr);
    int len;
    len = (seqLenCode == 4'd0) ? 16 : int'(seqLenCode);
    if (st) begin
      expFlag = '0; expDone = 1'b0; expIdx = '0; expCnt = 0; expBusy = 1'b1;
    end else begin
      expFlag = expFlag & ~clr;
      if (cv && expBusy) begin
        expRes[expIdx]  = d;
        expFlag[expIdx] = 1'b1;
        if (expCnt == len - 1) begin
          expDone = 1'b1;
          expCnt  = 0;
          expBusy = autoRepeat;
          expIdx  = ringMode ? expIdx + 4'd1 : 4'd0;
        end else begin
          expCnt++;
          expIdx = expIdx + 4'd1;
        end
      end
    end
  endtask

  task automatic step(input logic st, input logic cv, input logic [9:0] d,
                      input logic [15:0] clr, input string tag);
    startPulse = st; convDone = cv; convData = d; flagClr = clr;
    @(posedge clk);
    modelStep(st, cv, d, clr);
    #1;
    startPulse = 1'b0; convDone = 1'b0; flagClr = '0;
    compareAll(tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) expRes[i] = '0;
    expFlag = '0; expDone = 0; expIdx = 0; expBusy = 0; expCnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compareAll("R1");

    // R12: pulses before any start are ignored
    step(0, 1, 10'h155, '0, "R12");

    // R2 / R7 / R10: every length code, plain mode, single sequence
    for (int code = 0; code < 16; code++) begin
      int len;
      seqLenCode = 4'(code); ringMode = 0; autoRepeat = 0;
      len = (code == 0) ? 16 : code;
      step(1, 0, '0, '0, "R11");
      for (int k = 0; k < len; k++)
        step(0, 1, 10'(code * 37 + k * 5 + 1), '0, (k == len - 1) ? "R7" : "R2");
      step(0, 1, 10'h3FF, '0, "R12");
    end

    // R10: repeat mode in plain placement, length 5
    seqLenCode = 4'd5; autoRepeat = 1;
    step(1, 0, '0, '0, "R5");
    for (int k = 0; k < 12; k++) step(0, 1, 10'(200 + k), '0, "R10");

    // R9: clear some flags individually
    step(0, 0, '0, 16'h0014, "R9");
    step(0, 0, '0, 16'h8001, "R9");

    // R8: write and clear of the same register together
    step(0, 1, 10'h2AA, 16'd1 << convIdx, "R8");
    step(0, 1, 10'h0C3, 16'hFFFF, "R8");

    // R3 / R4 / R6: ring mode with repeat, length 3, enough to wrap twice
    seqLenCode = 4'd3; ringMode = 1; autoRepeat = 1;
    step(1, 0, '0, '0, "R5");
    for (int k = 0; k < 40; k++)
      step(0, 1, 10'(500 + k * 3), '0, (convIdx == 4'd15) ? "R4" : ((k % 3 == 2) ? "R3" : "R6"));

    // R11 / R5: start together with a conversion mid-sequence
    step(1, 1, 10'h111, '0, "R11");
    step(0, 1, 10'h222, '0, "R5");

    // ring mode without repeat: go idle, then restart at register 0
    seqLenCode = 4'd4; autoRepeat = 0;
    step(1, 0, '0, '0, "R5");
    for (int k = 0; k < 6; k++) step(0, 1, 10'(700 + k), '0, (k < 4) ? "R10" : "R12");
    step(1, 0, '0, '0, "R5");
    step(0, 1, 10'h0AB, '0, "R5");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule